// File: doc/BRIEF.md
# Single-Register MDIO Management Master

This block drives a clause-22 management bus from one 32-bit command word. Software waits for the busy flag to be clear. It then writes one word that names the target PHY, the register inside it, the direction, an enable flag, a busy flag and, for a write, the payload. The block runs the whole frame on its own. It clears busy when the frame ends, and after a read it places the returned halfword in the low half of the same word. Software polls that word until busy falls.

MDC is produced from the system clock by a programmable divider and runs only while a frame is in flight. The block drives MDIO while MDC is low and samples it on the rising MDC edge. During a read it releases the line from the turnaround onward.

A command aimed at a PHY address outside the supported range is retired without any bus activity.

Top module: `mdio_cmd_master`

## Requirements
- R1: A write of the command word with bit 31 (busy) and bit 30 (enable) both 1 and a valid PHY address starts a frame. Busy reads back 1 while the frame runs and 0 after it ends. The frame has exactly 64 MDC rising edges.
- R2: Each frame is sent MSB first as 32 ones, start 01, opcode (10 read, 01 write), 5 PHY address bits, 5 register bits, turnaround and 16 data bits. A write drives turnaround 10.
- R3: In a read the block stops driving MDIO (mdio_oe_o low) for the last 18 bit periods (turnaround plus data). It captures the 16 data bits from mdio_i on MDC rising edges and places them in bits 15:0.
- R4: Field positions are as follows: data in 15:0, register address in 20:16, PHY address in 25:21, operation in bit 27 (1 read, 0 write), enable in bit 30 and busy in bit 31. After completion the word reads back as written with busy 0, except that bits 15:0 hold the read data after a read.
- R5: A command with PHY address NUM_PHYS (default 5) or more produces no MDC edge. Busy reads 0 on the cycle after the write. A read of this kind returns 16'hFFFF in bits 15:0, and a write keeps its data.
- R6: A word written with enable 0 is stored with busy 0 and starts no frame.
- R7: Command writes that arrive while busy is 1 are ignored.
- R8: MDC has a half period of DIV_HALF system clocks. MDIO changes only while MDC is low.
- R9: While idle, MDC is low and MDIO is not driven. After reset the command word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | Write strobe for the command word |
| cmd_wdata_i | input | 32 | Command word being written |
| cmd_rdata_o | output | 32 | Current command/status word |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for management data |
| mdio_i | input | 1 | Management data in |

## Verification
The bench captures every bit the master drives on each rising MDC edge, and a responder returns read data after the turnaround. Frames are compared in full against a model built from the fields.

The bench targets these corner cases:
- Commands to PHY addresses 5 and 31. A master that ignored the range would emit a frame, or would leave busy set.
- A word with enable clear. A master that started on busy alone would clock MDC.
- A second write during a frame. A master that accepted it would corrupt the readback or the frame.
- The turnaround in a read. A master that kept driving there would show mdio_oe_o high, and one that misaligned its capture would return shifted data.
- The MDC period, which is measured directly.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int DATA_LSB  = 0;
  localparam int REG_LSB   = 16;
  localparam int PHY_LSB   = 21;
  localparam int OP_BIT    = 27;
  localparam int EN_BIT    = 30;
  localparam int BUSY_BIT  = 31;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap &&  mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);
  localparam int CW = $clog2(FRAME_LEN);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] TA_BIT   = CW'(TA_POS);
  localparam logic [CW-1:0] DAT_BIT  = CW'(DATA_POS);

  logic [FRAME_LEN-1:0] sh_q;
  logic [CW-1:0]        cnt_q;
  logic                 active_q, rd_q;
  logic [DATA_W-1:0]    rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      rdata_q  <= '0;
    end else if (start_i) begin
      sh_q     <= {32'hFFFF_FFFF, 2'b01, (rd_i ? 2'b10 : 2'b01),
                   phy_i, reg_i, 2'b10, wdata_i};
      cnt_q    <= '0;
      active_q <= 1'b1;
      rd_q     <= rd_i;
    end else if (active_q) begin
      if (rise_i && rd_q && cnt_q >= DAT_BIT)
        rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (cnt_q == LAST_BIT) begin
          active_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  assign active_o  = active_q;
  assign done_o    = active_q && fall_i && (cnt_q == LAST_BIT);
  assign rdata_o   = rdata_q;
  assign mdio_o    = active_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o = active_q && !(rd_q && cnt_q >= TA_BIT);
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int NUM_PHYS = 5,
  parameter int DIV_HALF = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_we_i,
  input  logic [31:0] cmd_wdata_i,
  output logic [31:0] cmd_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [31:0]       cmd_q;
  logic              accept, go, phy_ok, start;
  logic              active, done, rise, fall;
  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] w_phy, w_reg;

  assign w_phy  = cmd_wdata_i[PHY_LSB +: ADDR_W];
  assign w_reg  = cmd_wdata_i[REG_LSB +: ADDR_W];
  assign accept = cmd_we_i && !cmd_q[BUSY_BIT];
  assign go     = cmd_wdata_i[BUSY_BIT] && cmd_wdata_i[EN_BIT];
  assign phy_ok = int'(w_phy) < NUM_PHYS;
  assign start  = accept && go && phy_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (accept) begin
      if (start)
        cmd_q <= cmd_wdata_i;
      else if (go && cmd_wdata_i[OP_BIT])
        cmd_q <= {1'b0, cmd_wdata_i[30:DATA_W], {DATA_W{1'b1}}};  // rejected read
      else
        cmd_q <= {1'b0, cmd_wdata_i[30:0]};
    end else if (done) begin
      cmd_q[BUSY_BIT] <= 1'b0;
      if (cmd_q[OP_BIT]) cmd_q[DATA_LSB +: DATA_W] <= rdata;
    end
  end

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) div_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_engine eng_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rd_i      (cmd_wdata_i[OP_BIT]),
    .phy_i     (w_phy),
    .reg_i     (w_reg),
    .wdata_i   (cmd_wdata_i[DATA_LSB +: DATA_W]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .active_o  (active),
    .done_o    (done),
    .rdata_o   (rdata),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  assign cmd_rdata_o = cmd_q;
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk #(
  parameter int NUM_PHYS = 5
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_we_i,
  input logic [31:0] cmd_wdata_i,
  input logic [31:0] cmd_rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  logic fire, bad_phy;
  assign fire    = cmd_we_i && !cmd_rdata_o[31] && cmd_wdata_i[31] && cmd_wdata_i[30];
  assign bad_phy = int'(cmd_wdata_i[25:21]) >= NUM_PHYS;

  AST_START_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !bad_phy |=> cmd_rdata_o[31]);  // R1
  AST_BAD_PHY_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && bad_phy |=> !cmd_rdata_o[31] && !mdc_o);  // R5
  AST_NO_EN_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && !cmd_rdata_o[31] && !cmd_wdata_i[30] |=> !cmd_rdata_o[31]);  // R6
  AST_BUSY_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rdata_o[31] && cmd_we_i |=> $stable(cmd_rdata_o[30:16]));  // R7
  AST_MDIO_MOVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mdio_o) |-> !mdc_o);  // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_rdata_o[31] |-> !mdc_o && !mdio_oe_o);  // R9
  AST_WRITE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_rdata_o[31] && !cmd_rdata_o[27] |-> mdio_oe_o);  // R2
endmodule

bind mdio_cmd_master mdio_cmd_master_chk #(.NUM_PHYS(NUM_PHYS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_we_i    (cmd_we_i),
  .cmd_wdata_i (cmd_wdata_i),
  .cmd_rdata_o (cmd_rdata_o),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o)
);

// File: tb/mdio_cmd_master_tb_top.sv
`timescale 1ns/1ps
module mdio_cmd_master_tb_top;
  localparam int DIV_HALF = 4;
  localparam int NUM_PHYS = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we_i = 1'b0;
  logic [31:0] cmd_wdata_i = '0;
  logic [31:0] cmd_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int n_chk = 0, n_fail = 0;
  int rise_cnt = 0;
  logic [63:0] cap = '0, oecap = '0;
  logic [15:0] resp_data = '0;
  realtime t_r1 = 0, t_r2 = 0;
  logic busy_after;

  always #2 clk_i = ~clk_i;

  mdio_cmd_master #(.NUM_PHYS(NUM_PHYS), .DIV_HALF(DIV_HALF)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_we_i(cmd_we_i), .cmd_wdata_i(cmd_wdata_i),
    .cmd_rdata_o(cmd_rdata_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  // bus monitor and PHY responder
  always @(posedge mdc_o) begin
    cap   = {cap[62:0], mdio_o};
    oecap = {oecap[62:0], mdio_oe_o};
    if (rise_cnt == 0) t_r1 = $realtime;
    else if (rise_cnt == 1) t_r2 = $realtime;
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc_o) begin
    if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = resp_data[63 - rise_cnt];
  end

  function automatic logic [63:0] exp_frame(logic [4:0] phy, logic [4:0] rg, logic rd,
                                            logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
  endfunction

  function automatic logic [31:0] mk_cmd(logic busy, logic en, logic rd, logic [4:0] phy,
                                         logic [4:0] rg, logic [15:0] d);
    return {busy, en, 2'b00, rd, 1'b0, phy, rg, d};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [31:0] w);
    @(negedge clk_i);
    cmd_we_i = 1'b1;
    cmd_wdata_i = w;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
    busy_after = cmd_rdata_o[31];
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && cmd_rdata_o[31]; i++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic run_cmd(logic [31:0] w, logic [15:0] resp);
    rise_cnt = 0;
    resp_data = resp;
    mdio_i = 1'b1;
    issue(w);
    wait_idle();
  endtask

  // full check of a valid transaction
  task automatic valid_txn(logic rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d,
                           logic [15:0] resp);
    logic [31:0] w;
    logic [63:0] ef;
    w  = mk_cmd(1'b1, 1'b1, rd, phy, rg, d);
    ef = exp_frame(phy, rg, rd, d);
    run_cmd(w, resp);
    chk("R1 busy set after start", 64'(busy_after), 64'd1);
    chk("R1 mdc rising edges", 64'(rise_cnt), 64'd64);
    chk("R9 idle mdc/oe", {62'd0, mdc_o, mdio_oe_o}, 64'd0);
    if (rd) begin
      chk("R2 read frame header", 64'(cap[63:18]), 64'(ef[63:18]));
      chk("R3 read release", oecap, ~64'd0 << 18);
      chk("R3 R4 read readback", 64'(cmd_rdata_o), 64'({1'b0, w[30:16], resp}));
    end else begin
      chk("R2 write frame", cap, ef);
      chk("R2 write drive", oecap, ~64'd0);
      chk("R4 write readback", 64'(cmd_rdata_o), 64'({1'b0, w[30:0]}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] w, w2;
    int seed_init;
    seed_init = $urandom(32'd1234);
    repeat (3) @(negedge clk_i);
    chk("R9 reset word", 64'(cmd_rdata_o), 64'd0);
    chk("R9 reset bus", {62'd0, mdc_o, mdio_oe_o}, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed write and MDC period
    valid_txn(1'b0, 5'd1, 5'h0A, 16'hA5C3, 16'h0000);
    chk("R8 mdc period", 64'(int'((t_r2 - t_r1) * 1000)), 64'(2 * DIV_HALF * 4 * 1000));
    // directed reads, edge patterns
    valid_txn(1'b1, 5'd4, 5'h1F, 16'h0000, 16'h8001);
    valid_txn(1'b1, 5'd0, 5'h00, 16'h1234, 16'hFFFF);
    valid_txn(1'b0, 5'd4, 5'h1F, 16'hFFFF, 16'h0000);

    // out-of-range PHY
    w = mk_cmd(1'b1, 1'b1, 1'b1, 5'd5, 5'h03, 16'h1357);
    run_cmd(w, 16'h0000);
    chk("R5 bad phy busy", 64'(busy_after), 64'd0);
    chk("R5 bad phy no mdc", 64'(rise_cnt), 64'd0);
    chk("R5 bad phy read data", 64'(cmd_rdata_o), 64'({1'b0, w[30:16], 16'hFFFF}));
    w = mk_cmd(1'b1, 1'b1, 1'b0, 5'd31, 5'h07, 16'h2468);
    run_cmd(w, 16'h0000);
    chk("R5 bad phy write busy", 64'(busy_after), 64'd0);
    chk("R5 bad phy write no mdc", 64'(rise_cnt), 64'd0);
    chk("R5 bad phy write data", 64'(cmd_rdata_o), 64'({1'b0, w[30:0]}));

    // enable clear
    w = mk_cmd(1'b1, 1'b0, 1'b1, 5'd2, 5'h05, 16'h0F0F);
    run_cmd(w, 16'h0000);
    chk("R6 no enable busy", 64'(busy_after), 64'd0);
    chk("R6 no enable no mdc", 64'(rise_cnt), 64'd0);
    chk("R6 no enable stored", 64'(cmd_rdata_o), 64'({1'b0, w[30:0]}));

    // write while busy
    w  = mk_cmd(1'b1, 1'b1, 1'b0, 5'd3, 5'h11, 16'hC0DE);
    w2 = mk_cmd(1'b1, 1'b1, 1'b1, 5'd1, 5'h02, 16'h5555);
    rise_cnt = 0;
    mdio_i = 1'b1;
    issue(w);
    repeat (20) @(negedge clk_i);
    issue(w2);
    chk("R7 busy write ignored live", 64'(cmd_rdata_o[30:0]), 64'(w[30:0]));
    wait_idle();
    chk("R7 frame unchanged", cap, exp_frame(5'd3, 5'h11, 1'b0, 16'hC0DE));
    chk("R7 readback unchanged", 64'(cmd_rdata_o), 64'({1'b0, w[30:0]}));

    // constrained random
    for (int k = 0; k < 12; k++) begin
      logic rd;
      logic [4:0] phy, rg;
      logic [15:0] d, r;
      rd  = 1'($urandom);
      phy = 5'($urandom % NUM_PHYS);
      rg  = 5'($urandom);
      d   = 16'($urandom);
      r   = 16'($urandom);
      valid_txn(rd, phy, rg, d, r);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule